// File: doc/BRIEF.md
# I2S Master Frame Engine

This block makes standard I2S frames when it is the clock master. It produces the bit clock and the word-select line. It shifts one left sample and one right sample out on the serial data line in every frame. At the same time it captures the serial input into parallel words. Transmit samples come from an upstream first-word-fall-through FIFO through an empty flag, a data bus and a read strobe. Each received word is pushed downstream with a strobe and a phase flag.

A single control register sets the configuration:

- the frame length code, with both halves always equal;
- the sample width, held as a plain bit count and shared by both channels;
- the sampling-rate code, which is held for readback only;
- master or slave mode;
- separate receive and transmit enables.

The bit-clock rate comes from a divide input. This stands in for the rate-dependent clock generation of a full system. While either enable is set, every field except the two enables is frozen.

Top module: `i2s_frame_engine`

## Requirements
- R1: Control bits [10:8] hold the frame code: 0 gives 32, 1 gives 48, 2 gives 64 and 3 gives 128 bit clocks per frame. A write carrying a code above 3 leaves the field unchanged. Word-select is low for the first half (left) and high for the second half (right). Each half is half the frame.
- R2: Control bits [4:0] hold the sample width as a bit count. Only 8, 16 and 24 are accepted; any other value written leaves the field unchanged. The reset value is 16.
- R3: Control bits [15:12] hold the rate code. The codes 0 to 5 and 8 to 10 are accepted; any other written code leaves the field unchanged. The reset value is 0.
- R4: Control bit 24 is the receive enable and bit 25 is the transmit enable. Both are written on every control write, including while the engine runs.
- R5: While bit 24 or bit 25 reads as set, a control write leaves bits [16:0] unchanged.
- R6: Control bit 16 selects master mode, and `drive_clk` mirrors it.
  - The engine runs only when master mode is set and at least one enable is set.
  - While it runs, `sck` toggles every `clk_div`+1 clock cycles, starting low with slot 0 of the left half.
  - When the engine is not running, `sck`, `ws` and `sd_out` are low from the next cycle.
- R7: Slot 0 of each half transmits 0. Slot i, for 1 ≤ i ≤ W where W is the sample width, transmits bit W−i of the loaded sample, so the MSB goes out one bit clock after the word-select edge. Slots beyond W transmit 0, and sample bits at or above W are never sent. The data changes on falling `sck`.
- R8: With transmit enabled, the first rising `sck` edge of each half loads one sample if the FIFO is not empty. The left sample is loaded first. `tx_rd` is high for the one cycle after that edge.
- R9: If the transmit FIFO is empty at a load point, the half transmits all zeros. `tx_urun[0]` pulses for one cycle for a left half, or `tx_urun[1]` for a right half. No read happens.
- R10: With receive enabled, `sd_in` is sampled on rising `sck`. The bit in slot i lands in bit W−i of the word. Bits in slots 0 and beyond W are ignored, and bits that were not received read as zero. At the rising edge of a half's last slot, the word is pushed with `rx_wr` for one cycle. `rx_right` marks which half the word came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register readback |
| clk_div | input | 8 | Bit-clock half-period minus one, in clock cycles |
| drive_clk | output | 1 | High when the block owns sck and ws (master mode) |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select: low for left, high for right |
| sd_out | output | 1 | Serial transmit data |
| sd_in | input | 1 | Serial receive data |
| tx_empty | input | 1 | Upstream FIFO empty |
| tx_data | input | 24 | Upstream FIFO head sample, right-aligned |
| tx_rd | output | 1 | Upstream FIFO read strobe |
| tx_urun | output | 2 | Underrun pulse per phase: bit 0 left, bit 1 right |
| rx_wr | output | 1 | Downstream FIFO write strobe |
| rx_data | output | 24 | Received sample, right-aligned |
| rx_right | output | 1 | Phase of the pushed word: 1 means right |

## Verification
A control write is visible in `cfg_rdata` on the first sample point after the clock edge that accepts it. An enable change takes effect on `sck`, `ws` and `sd_out` one cycle later, because the run condition is read from the register. Every serial event is tied to a bit-clock tick that falls exactly `clk_div`+1 cycles after the previous one. Data and word-select move on the falling tick. Sample loads, underrun pulses and receive pushes are raised on the cycle after the rising tick of the right slot. The reference model advances its own tick counter by one step per clock edge and predicts every output for that cycle. The bench compares all outputs in the middle of each clock period, so each result is checked in the exact cycle it becomes due and in no other.

// File: rtl/i2s_eng_pkg.sv
package i2s_eng_pkg;
  localparam int CFG_W    = 32;
  localparam int LEN_W    = 5;
  localparam int FCODE_W  = 3;
  localparam int RATE_W   = 4;
  localparam int LEN_LSB  = 0;
  localparam int FRM_LSB  = 8;
  localparam int RATE_LSB = 12;
  localparam int MST_BIT  = 16;
  localparam int RXEN_BIT = 24;
  localparam int TXEN_BIT = 25;
  localparam int SLOT_W   = 7;   // largest frame is 128 slots
  localparam int FLEN_W   = 8;

  function automatic logic [FLEN_W-1:0] frame_bits(input logic [FCODE_W-1:0] code);
    case (code)
      3'd0:    return 8'd32;
      3'd1:    return 8'd48;
      3'd2:    return 8'd64;
      default: return 8'd128;
    endcase
  endfunction

  function automatic logic len_ok(input logic [LEN_W-1:0] v);
    return (v == 5'd8) || (v == 5'd16) || (v == 5'd24);
  endfunction

  function automatic logic rate_ok(input logic [RATE_W-1:0] r);
    return (r <= 4'd5) || ((r >= 4'd8) && (r <= 4'd10));
  endfunction
endpackage

// File: rtl/i2s_cfg_reg.sv
module i2s_cfg_reg
  import i2s_eng_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [CFG_W-1:0]   wdata,
  output logic [LEN_W-1:0]   len,
  output logic [FCODE_W-1:0] fcode,
  output logic [RATE_W-1:0]  rate,
  output logic               master,
  output logic               rx_en,
  output logic               tx_en,
  output logic [CFG_W-1:0]   rdata
);
  logic busy;
  logic [LEN_W-1:0]   w_len;
  logic [FCODE_W-1:0] w_fc;
  logic [RATE_W-1:0]  w_rate;

  assign busy   = rx_en | tx_en;
  assign w_len  = wdata[LEN_LSB +: LEN_W];
  assign w_fc   = wdata[FRM_LSB +: FCODE_W];
  assign w_rate = wdata[RATE_LSB +: RATE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      len    <= 5'd16;
      fcode  <= '0;
      rate   <= '0;
      master <= 1'b0;
      rx_en  <= 1'b0;
      tx_en  <= 1'b0;
    end else if (wr) begin
      rx_en <= wdata[RXEN_BIT];
      tx_en <= wdata[TXEN_BIT];
      if (!busy) begin
        if (len_ok(w_len))     len   <= w_len;
        if (w_fc <= 3'd3)      fcode <= w_fc;
        if (rate_ok(w_rate))   rate  <= w_rate;
        master <= wdata[MST_BIT];
      end
    end
  end

  always_comb begin
    rdata = '0;
    rdata[LEN_LSB +: LEN_W]    = len;
    rdata[FRM_LSB +: FCODE_W]  = fcode;
    rdata[RATE_LSB +: RATE_W]  = rate;
    rdata[MST_BIT]             = master;
    rdata[RXEN_BIT]            = rx_en;
    rdata[TXEN_BIT]            = tx_en;
  end
endmodule

// File: rtl/i2s_bit_timer.sv
module i2s_bit_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick = run && (cnt == div);
  assign rise = tick & ~sck;
  assign fall = tick & sck;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2s_frame_seq.sv
module i2s_frame_seq
  import i2s_eng_pkg::*;
#(
  parameter int SMP_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               tx_en,
  input  logic               rx_en,
  input  logic [LEN_W-1:0]   len,
  input  logic [FCODE_W-1:0] fcode,
  input  logic               rise,
  input  logic               fall,
  input  logic               tx_empty,
  input  logic [SMP_W-1:0]   tx_data,
  input  logic               sd_in,
  output logic               ws,
  output logic               sd_out,
  output logic               tx_rd,
  output logic [1:0]         tx_urun,
  output logic               rx_wr,
  output logic [SMP_W-1:0]   rx_data,
  output logic               rx_right
);
  logic [FLEN_W-1:0] flen;
  logic [SLOT_W-1:0] half, slot, idx, nslot, nidx;
  logic              right, nright, nbit, in_rng;
  logic [SMP_W-1:0]  tx_hold, rx_acc, rx_nxt, rx_mask;

  assign flen   = frame_bits(fcode);
  assign half   = flen[FLEN_W-1:1];
  assign right  = (slot >= half);
  assign idx    = right ? slot - half : slot;
  assign nslot  = ({1'b0, slot} == flen - 8'd1) ? '0 : slot + 1'b1;
  assign nright = (nslot >= half);
  assign nidx   = nright ? nslot - half : nslot;

  // position i of a half carries sample bit (W - i) for 1 <= i <= W
  function automatic logic pick(input logic [SMP_W-1:0] h,
                                input logic [SLOT_W-1:0] i,
                                input logic [LEN_W-1:0] w);
    logic [SMP_W-1:0] s;
    s = '0;
    if ((i != '0) && (i <= SLOT_W'(w)))
      s = h >> (w - LEN_W'(i));
    return s[0];
  endfunction

  assign nbit    = pick(tx_hold, nidx, len);
  assign in_rng  = (idx != '0) && (idx <= SLOT_W'(len));
  assign rx_mask = in_rng ? (SMP_W'(1) << (len - LEN_W'(idx))) : '0;
  assign rx_nxt  = ((idx == '0) ? '0 : rx_acc) | (sd_in ? rx_mask : '0);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      slot    <= '0;
      ws      <= 1'b0;
      sd_out  <= 1'b0;
      tx_hold <= '0;
      rx_acc  <= '0;
      tx_rd   <= 1'b0;
      tx_urun <= '0;
      rx_wr   <= 1'b0;
      if (rst) begin
        rx_data  <= '0;
        rx_right <= 1'b0;
      end
    end else begin
      tx_rd   <= 1'b0;
      tx_urun <= '0;
      rx_wr   <= 1'b0;
      if (fall) begin
        slot   <= nslot;
        ws     <= nright;
        sd_out <= nbit;
      end
      if (rise) begin
        if ((idx == '0) && tx_en) begin
          if (!tx_empty) begin
            tx_hold <= tx_data;
            tx_rd   <= 1'b1;
          end else begin
            tx_hold <= '0;
            tx_urun <= right ? 2'b10 : 2'b01;
          end
        end
        if (rx_en) begin
          rx_acc <= rx_nxt;
          if (idx == half - 1'b1) begin
            rx_data  <= rx_nxt;
            rx_wr    <= 1'b1;
            rx_right <= right;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2s_frame_engine.sv
module i2s_frame_engine
  import i2s_eng_pkg::*;
#(
  parameter int SMP_W = 24,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [DIV_W-1:0]  clk_div,
  output logic              drive_clk,
  output logic              sck,
  output logic              ws,
  output logic              sd_out,
  input  logic              sd_in,
  input  logic              tx_empty,
  input  logic [SMP_W-1:0]  tx_data,
  output logic              tx_rd,
  output logic [1:0]        tx_urun,
  output logic              rx_wr,
  output logic [SMP_W-1:0]  rx_data,
  output logic              rx_right
);
  logic [LEN_W-1:0]   len;
  logic [FCODE_W-1:0] fcode;
  logic [RATE_W-1:0]  rate;
  logic master, rx_en, tx_en, run, rise, fall;

  assign run       = master & (rx_en | tx_en);
  assign drive_clk = master;

  i2s_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
    .len(len), .fcode(fcode), .rate(rate), .master(master),
    .rx_en(rx_en), .tx_en(tx_en), .rdata(cfg_rdata)
  );

  i2s_bit_timer #(.DIV_W(DIV_W)) u_tmr (
    .clk(clk), .rst(rst), .run(run), .div(clk_div),
    .sck(sck), .rise(rise), .fall(fall)
  );

  i2s_frame_seq #(.SMP_W(SMP_W)) u_seq (
    .clk(clk), .rst(rst), .run(run), .tx_en(tx_en), .rx_en(rx_en),
    .len(len), .fcode(fcode), .rise(rise), .fall(fall),
    .tx_empty(tx_empty), .tx_data(tx_data), .sd_in(sd_in),
    .ws(ws), .sd_out(sd_out), .tx_rd(tx_rd), .tx_urun(tx_urun),
    .rx_wr(rx_wr), .rx_data(rx_data), .rx_right(rx_right)
  );
endmodule

// File: rtl/i2s_frame_engine_chk.sv
module i2s_frame_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] cfg_rdata,
  input logic        sck,
  input logic        ws,
  input logic        sd_out,
  input logic        tx_rd,
  input logic [1:0]  tx_urun,
  input logic        rx_wr
);
  p_frame_code_r1: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[10:8] <= 3'd3);

  p_ws_on_fall_r1: assert property (@(posedge clk) disable iff (rst)
    !$stable(ws) |-> ($fell(sck) || !ws));

  p_len_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[4:0] == 5'd8) || (cfg_rdata[4:0] == 5'd16) || (cfg_rdata[4:0] == 5'd24));

  p_lock_r5: assert property (@(posedge clk) disable iff (rst)
    (|cfg_rdata[25:24]) |=> (cfg_rdata[16:0] == $past(cfg_rdata[16:0])));

  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_rdata[16] || (cfg_rdata[25:24] == 2'b00)) |=> (!sck && !ws && !sd_out));

  p_rd_needs_tx_r8: assert property (@(posedge clk) disable iff (rst)
    tx_rd |-> $past(cfg_rdata[25]));

  p_rd_urun_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(tx_rd && (|tx_urun)));

  p_urun_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tx_urun));

  p_rxwr_needs_rx_r10: assert property (@(posedge clk) disable iff (rst)
    rx_wr |-> $past(cfg_rdata[24]));
endmodule

bind i2s_frame_engine i2s_frame_engine_chk u_chk (
  .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .sck(sck), .ws(ws),
  .sd_out(sd_out), .tx_rd(tx_rd), .tx_urun(tx_urun), .rx_wr(rx_wr)
);

// File: tb/sim_i2s_frame_engine.sv
module sim_i2s_frame_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  clk_div = 8'd0;
  logic        drive_clk, sck, ws, sd_out, sd_in;
  logic        tx_empty = 1'b1;
  logic [23:0] tx_data = '0;
  logic        tx_rd, rx_wr, rx_right;
  logic [1:0]  tx_urun;
  logic [23:0] rx_data;
  logic        loop = 1'b1;

  int checks = 0;
  int errors = 0;
  logic [23:0] txq[$];
  int rxw[$];
  int rxr[$];
  bit sck_seen;

  always #10 clk = ~clk;
  assign sd_in = loop ? sd_out : 1'b1;

  i2s_frame_engine u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .clk_div(clk_div), .drive_clk(drive_clk), .sck(sck), .ws(ws), .sd_out(sd_out),
    .sd_in(sd_in), .tx_empty(tx_empty), .tx_data(tx_data), .tx_rd(tx_rd),
    .tx_urun(tx_urun), .rx_wr(rx_wr), .rx_data(rx_data), .rx_right(rx_right)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic fifo_refresh();
    tx_empty = (txq.size() == 0);
    tx_data  = (txq.size() > 0) ? txq[0] : 24'h0;
  endtask

  // environment FIFO: consume on the read strobe, mid-cycle
  always @(negedge clk) begin
    if (!rst && tx_rd && txq.size() > 0) begin
      void'(txq.pop_front());
      fifo_refresh();
    end
  end

  // ---------------- reference model ----------------
  int m_len, m_fc, m_rate, m_ms, m_rx, m_tx, m_div, m_slot, m_hold, m_acc;
  bit e_sck, e_ws, e_sd, e_rd, e_rxwr, e_rxr, started;
  logic [1:0] e_ur;
  int e_rxd;

  always @(posedge clk) begin
    int fl, hf, w, idx;
    bit run, tick, rt, bin, busy;
    started = 1'b1;
    if (rst) begin
      m_len = 16; m_fc = 0; m_rate = 0; m_ms = 0; m_rx = 0; m_tx = 0;
      m_div = 0; m_slot = 0; m_hold = 0; m_acc = 0;
      e_sck = 0; e_ws = 0; e_sd = 0; e_rd = 0; e_ur = 2'b00; e_rxwr = 0; e_rxd = 0; e_rxr = 0;
    end else begin
      fl = (m_fc == 0) ? 32 : (m_fc == 1) ? 48 : (m_fc == 2) ? 64 : 128;
      hf = fl / 2;
      w  = m_len;
      run = (m_ms != 0) && ((m_rx != 0) || (m_tx != 0));
      e_rd = 0; e_ur = 2'b00; e_rxwr = 0;
      if (!run) begin
        m_div = 0; e_sck = 0; e_ws = 0; e_sd = 0; m_slot = 0; m_hold = 0; m_acc = 0;
      end else begin
        tick  = (m_div == int'(clk_div));
        m_div = tick ? 0 : m_div + 1;
        if (tick && e_sck) begin
          m_slot = (m_slot + 1) % fl;
          e_ws   = (m_slot >= hf);
          idx    = m_slot % hf;
          e_sd   = (idx >= 1 && idx <= w) ? (((m_hold >> (w - idx)) & 1) != 0) : 1'b0;
          e_sck  = 0;
        end else if (tick) begin
          idx = m_slot % hf;
          rt  = (m_slot >= hf);
          if (idx == 0 && m_tx != 0) begin
            if (txq.size() > 0) begin m_hold = int'(txq[0]); e_rd = 1; end
            else begin m_hold = 0; e_ur = rt ? 2'b10 : 2'b01; end
          end
          if (m_rx != 0) begin
            bin = loop ? e_sd : 1'b1;
            if (idx == 0) m_acc = 0;
            if (idx >= 1 && idx <= w && bin) m_acc = m_acc | (1 << (w - idx));
            if (idx == hf - 1) begin e_rxd = m_acc; e_rxwr = 1; e_rxr = rt; end
          end
          e_sck = 1;
        end
      end
      if (cfg_wr) begin
        busy = (m_rx != 0) || (m_tx != 0);
        m_rx = int'(cfg_wdata[24]);
        m_tx = int'(cfg_wdata[25]);
        if (!busy) begin
          if (cfg_wdata[10:8] <= 3'd3) m_fc = int'(cfg_wdata[10:8]);
          if (cfg_wdata[4:0] == 5'd8 || cfg_wdata[4:0] == 5'd16 || cfg_wdata[4:0] == 5'd24)
            m_len = int'(cfg_wdata[4:0]);
          if (cfg_wdata[15:12] <= 4'd5 || (cfg_wdata[15:12] >= 4'd8 && cfg_wdata[15:12] <= 4'd10))
            m_rate = int'(cfg_wdata[15:12]);
          m_ms = int'(cfg_wdata[16]);
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      check(cfg_rdata[4:0] == 5'(m_len), "R2 length field", int'(cfg_rdata[4:0]), m_len);
      check(cfg_rdata[10:8] == 3'(m_fc), "R1 frame field", int'(cfg_rdata[10:8]), m_fc);
      check(cfg_rdata[15:12] == 4'(m_rate), "R3 rate field", int'(cfg_rdata[15:12]), m_rate);
      check(cfg_rdata[25:24] == {1'(m_tx), 1'(m_rx)}, "R4 enables", int'(cfg_rdata[25:24]), m_tx * 2 + m_rx);
      check(cfg_rdata[16] == 1'(m_ms) && drive_clk == 1'(m_ms), "R6 master/drive_clk", int'(drive_clk), m_ms);
      check(sck == e_sck, "R6 sck", int'(sck), int'(e_sck));
      check(ws == e_ws, "R1 ws", int'(ws), int'(e_ws));
      check(sd_out == e_sd, "R7 sd_out", int'(sd_out), int'(e_sd));
      check(tx_rd == e_rd, "R8 tx_rd", int'(tx_rd), int'(e_rd));
      check(tx_urun == e_ur, "R9 tx_urun", int'(tx_urun), int'(e_ur));
      check(rx_wr == e_rxwr, "R10 rx_wr", int'(rx_wr), int'(e_rxwr));
      if (rx_wr && e_rxwr) begin
        check(int'(rx_data) == e_rxd && rx_right == e_rxr, "R10 rx word",
              int'(rx_data), e_rxd);
        rxw.push_back(int'(rx_data));
        rxr.push_back(int'(rx_right));
      end
      if (sck) sck_seen = 1'b1;
    end
  end

  function automatic logic [31:0] mk(int tx, int rx, int ms, int rate, int fc, int len);
    return 32'((tx << 25) | (rx << 24) | (ms << 16) | (rate << 12) | (fc << 8) | len);
  endfunction

  task automatic cfg_write(input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic push(input logic [23:0] s);
    txq.push_back(s);
    fifo_refresh();
  endtask

  task automatic run_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cfg_rdata == 32'h0000_0010, "R2 reset value", int'(cfg_rdata), 32'h10);
    check(sck == 1'b0 && ws == 1'b0, "R6 reset idle", int'(sck), 0);

    // illegal codes while idle: fields keep their values, master is taken
    cfg_write(mk(0, 0, 1, 6, 5, 12));
    @(negedge clk);
    check(cfg_rdata[10:8] == 3'd0, "R1 illegal frame code", int'(cfg_rdata[10:8]), 0);
    check(cfg_rdata[4:0] == 5'd16, "R2 illegal length", int'(cfg_rdata[4:0]), 16);
    check(cfg_rdata[15:12] == 4'd0, "R3 illegal rate", int'(cfg_rdata[15:12]), 0);
    run_cycles(4);
    check(sck == 1'b0, "R6 master without enable stays idle", int'(sck), 0);

    // 64-bit frame, 24-bit samples, loopback, then underrun
    clk_div = 8'd0;
    loop = 1'b1;
    cfg_write(mk(0, 0, 1, 10, 2, 24));
    push(24'hA5C3F1); push(24'h123456); push(24'h800001); push(24'h7FFFFE);
    rxw.delete(); rxr.delete();
    cfg_write(mk(1, 1, 1, 10, 2, 24));
    check(cfg_rdata[25:24] == 2'b11, "R4 enables set", int'(cfg_rdata[25:24]), 3);
    run_cycles(100);
    cfg_write(mk(1, 1, 0, 3, 0, 8));
    @(negedge clk);
    check(cfg_rdata[16:0] == 17'h1_A218, "R5 locked fields", int'(cfg_rdata[16:0]), 32'h1A218);
    run_cycles(250);
    check(rxw.size() >= 4, "R10 word count", rxw.size(), 4);
    if (rxw.size() >= 4) begin
      check(rxw[0] == 32'hA5C3F1 && rxr[0] == 0, "R7 left loopback", rxw[0], 32'hA5C3F1);
      check(rxw[1] == 32'h123456 && rxr[1] == 1, "R7 right loopback", rxw[1], 32'h123456);
      check(rxw[3] == 32'h7FFFFE, "R8 fourth sample in order", rxw[3], 32'h7FFFFE);
    end
    if (rxw.size() >= 5)
      check(rxw[4] == 0, "R9 underrun sends zeros", rxw[4], 0);
    cfg_write(mk(0, 0, 1, 10, 2, 24));
    run_cycles(4);

    // 48-bit frame, 16-bit samples: upper sample bits never sent
    push(24'hFF1234); push(24'h00ABCD);
    rxw.delete(); rxr.delete();
    cfg_write(mk(0, 0, 1, 5, 1, 16));
    cfg_write(mk(1, 1, 1, 5, 1, 16));
    run_cycles(100);
    check(rxw.size() >= 2, "R1 48-bit frame words", rxw.size(), 2);
    if (rxw.size() >= 2) begin
      check(rxw[0] == 32'h1234, "R7 bits above width dropped", rxw[0], 32'h1234);
      check(rxw[1] == 32'hABCD, "R7 right 16-bit", rxw[1], 32'hABCD);
    end
    cfg_write(mk(0, 0, 1, 5, 1, 16));
    run_cycles(4);

    // 32-bit frame, 24-bit samples: only 15 MSBs fit each half
    push(24'hFFFFFF); push(24'hC00003);
    rxw.delete(); rxr.delete();
    cfg_write(mk(0, 0, 1, 0, 0, 24));
    cfg_write(mk(1, 1, 1, 0, 0, 24));
    run_cycles(70);
    if (rxw.size() >= 2) begin
      check(rxw[0] == 32'hFFFE00, "R10 unreceived bits zero", rxw[0], 32'hFFFE00);
      check(rxw[1] == 32'hC00000, "R10 right truncated", rxw[1], 32'hC00000);
    end else check(1'b0, "R10 32-bit frame words", rxw.size(), 2);
    cfg_write(mk(0, 0, 1, 0, 0, 24));
    run_cycles(4);

    // 128-bit frame, 8-bit samples, receive only, sd_in held high, slower clock
    loop = 1'b0;
    clk_div = 8'd2;
    rxw.delete(); rxr.delete();
    cfg_write(mk(0, 0, 1, 8, 3, 8));
    cfg_write(mk(0, 1, 1, 8, 3, 8));
    run_cycles(800);
    check(rxw.size() >= 2, "R10 rx-only words", rxw.size(), 2);
    if (rxw.size() >= 2)
      check(rxw[0] == 32'hFF && rxw[1] == 32'hFF, "R10 bits past width ignored", rxw[1], 32'hFF);
    cfg_write(mk(0, 0, 1, 8, 3, 8));
    run_cycles(4);

    // slave mode with enables: nothing is driven
    sck_seen = 1'b0;
    cfg_write(mk(0, 0, 0, 8, 3, 8));
    cfg_write(mk(1, 1, 0, 8, 3, 8));
    run_cycles(200);
    check(!sck_seen && drive_clk == 1'b0, "R6 slave keeps sck idle", int'(sck_seen), 0);
    cfg_write(mk(0, 0, 0, 8, 3, 8));
    run_cycles(4);
    finish_sim();
  end
endmodule